// File: doc/BRIEF.md
# UART Interrupt Identification Controller

This block holds the interrupt-enable, interrupt-identification and line-status logic of a 16550-style serial port. A host reads and writes byte registers through a one-cycle strobe and a 3-bit offset. The receive FIFO, the transmitter and the modem-status logic sit next to this block. They report to it through a FIFO fill count, an overrun pulse, a modem-change-pending level and the FIFO-mode state.

The block ranks every pending cause by a fixed priority and presents the winner as an identification code. It drives one level interrupt whenever a cause is pending. It also keeps a transmit-empty pending flag. A data write or a rising transmit-enable bit sets the flag, and a read that reports it clears it. The line control register holds the divisor-latch access bit. While that bit is set, offsets 0 and 1 reach the two divisor bytes, which reset to the value for 9600 baud from a 1.8432 MHz reference.

Read data is combinational in the cycle of the read strobe. Side effects of a read or write appear from the next clock edge.

Top module: `uart_iic_top`

## Requirements
- R1: After reset the enable register reads 0x00, the line control register reads 0x00, the divisor reads low byte 0x0C and high byte 0x00, identification reads 0x01 and the interrupt is low.
- R2: A write to offset 1 keeps only bits 3:0. Bit 0 enables receive, bit 1 transmit-empty, bit 2 line status and bit 3 modem causes. Read-back shows zeros in bits 7:4.
- R3: Identification bits 3:0 report the highest enabled cause in this order: overrun 0x6, receive data present 0xC, transmit-empty pending 0x2, modem change 0x0. With no enabled cause they report 0x1.
- R4: A write to offset 0 with the access bit clear sets the transmit-empty pending flag.
- R5: A write to offset 1 that takes enable bit 1 from 0 to 1 sets the pending flag. Writing 1 over a 1 leaves the flag unchanged.
- R6: A read of offset 2 that returns code 0x2 clears the pending flag. A read returning any other code leaves the flag set.
- R7: Identification bits 7:6 read 11 when FIFO mode is on and 00 otherwise.
- R8: Offset 5 reads bits 6 and 5 as 1 and bit 0 as (FIFO count non-zero). Bit 1 is a sticky overrun flag that clears after an offset-5 read.
- R9: With line control bit 7 set, offsets 0 and 1 read and write the divisor low and high bytes. Such writes change neither the enable register nor the pending flag.
- R10: The interrupt output is high exactly when the identification code is not 0x1.
- R11: Reads of offsets 4, 6, 7, and of 0 with the access bit clear, return 0xFF. Writes to offset 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rx_count | input | CNT_W | Receive FIFO fill count |
| ovr_in | input | 1 | Overrun event pulse |
| modem_delta | input | 1 | Any modem change bit pending |
| fifo_en | input | 1 | FIFO mode enabled |
| rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest state to reach is a transmit-empty flag that is pending but hidden under a higher cause. That state shows whether a read clears the flag only when the read reports it. The stimulus first enables every cause and holds a non-zero FIFO count. It then writes the data register and reads the identification register, which returns 0xC. Only after the count drops to zero is 0x2 expected. The same sequence also covers the case of a write to offset 0 under the access bit, which must leave the flag alone.

// File: rtl/uart_iic_pkg.sv
// Package: shared offsets, enable-bit positions and identification codes
// for the UART interrupt identification controller.
package uart_iic_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    // Register offsets
    localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_IID  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_LCTL = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_LST  = 3'd5;

    // Enable-bit positions (decoded by software)
    localparam int EN_RX  = 0;
    localparam int EN_TX  = 1;
    localparam int EN_LS  = 2;
    localparam int EN_MS  = 3;
    localparam int EN_W   = 4;

    // Divisor access bit in the line control register
    localparam int LCTL_DIV_BIT = 7;

    // Identification codes (low nibble)
    localparam logic [3:0] ID_NONE = 4'h1;
    localparam logic [3:0] ID_LS   = 4'h6;
    localparam logic [3:0] ID_RXTO = 4'hC;
    localparam logic [3:0] ID_TX   = 4'h2;
    localparam logic [3:0] ID_MS   = 4'h0;

    // Cause table, index 0 is the highest priority
    localparam int NCAUSE = 4;
    localparam logic [3:0] CAUSE_CODE [NCAUSE] = '{ID_LS, ID_RXTO, ID_TX, ID_MS};

    localparam logic [1:0] FIFO_MARK = 2'b11;
    localparam logic [DATA_W-1:0] RD_UNUSED = 8'hFF;
endpackage

// File: rtl/uart_iic_regs.sv
// Module: uart_iic_regs
// Holds the enable register, the line control register, the two divisor
// bytes and the transmit-empty pending flag. It decodes the divisor access
// bit so that offsets 0 and 1 are steered to the divisor while it is set.
// Assumes that at most one strobe is active in a cycle.
module uart_iic_regs
    import uart_iic_pkg::*;
#(
    parameter int unsigned DIV_RESET = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_clr,
    output logic [EN_W-1:0]   ien_q,
    output logic [DATA_W-1:0] lctl_q,
    output logic [DATA_W-1:0] div_lo_q,
    output logic [DATA_W-1:0] div_hi_q,
    output logic              tx_pend_q,
    output logic              div_sel
);
    localparam logic [2*DATA_W-1:0] DIV_INIT = DIV_RESET[2*DATA_W-1:0];

    logic wr_div_lo, wr_div_hi, wr_data, wr_ien, wr_lctl, tx_rise;

    // Purpose: decode write strobes with divisor steering
    always_comb begin
        div_sel   = lctl_q[LCTL_DIV_BIT];
        wr_div_lo = wr_en &&  div_sel && (addr == OFS_DATA);
        wr_div_hi = wr_en &&  div_sel && (addr == OFS_IEN);
        wr_data   = wr_en && !div_sel && (addr == OFS_DATA);
        wr_ien    = wr_en && !div_sel && (addr == OFS_IEN);
        wr_lctl   = wr_en && (addr == OFS_LCTL);
        tx_rise   = wr_ien && !ien_q[EN_TX] && wdata[EN_TX];
    end

    // Purpose: enable and line control storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= '0;
            lctl_q <= '0;
        end else begin
            if (wr_ien)  ien_q  <= wdata[EN_W-1:0];
            if (wr_lctl) lctl_q <= wdata;
        end
    end

    // Purpose: divisor byte storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_lo_q <= DIV_INIT[DATA_W-1:0];
            div_hi_q <= DIV_INIT[2*DATA_W-1:DATA_W];
        end else begin
            if (wr_div_lo) div_lo_q <= wdata;
            if (wr_div_hi) div_hi_q <= wdata;
        end
    end

    // Purpose: transmit-empty pending flag, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)                 tx_pend_q <= 1'b0;
        else if (wr_data || tx_rise) tx_pend_q <= 1'b1;
        else if (tx_clr)            tx_pend_q <= 1'b0;
    end
endmodule

// File: rtl/uart_iic_lstat.sv
// Module: uart_iic_lstat
// Builds the line status byte: transmitter always idle, data-ready from the
// FIFO count, and a sticky overrun flag cleared after a status read.
// Assumes the overrun input is a one-cycle event.
module uart_iic_lstat
    import uart_iic_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_lst,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              ovr_in,
    output logic              ovr_q,
    output logic              rx_any,
    output logic [DATA_W-1:0] lst_val
);
    // Purpose: sticky overrun, a new event wins over the read clear
    always_ff @(posedge clk) begin
        if (!rst_n)      ovr_q <= 1'b0;
        else if (ovr_in) ovr_q <= 1'b1;
        else if (rd_lst) ovr_q <= 1'b0;
    end

    // Purpose: assemble status byte
    always_comb begin
        rx_any  = |rx_count;
        lst_val = {1'b0, 1'b1, 1'b1, 3'b000, ovr_q, rx_any};
    end
endmodule

// File: rtl/uart_iic_prio.sv
// Module: uart_iic_prio
// Fixed-priority encoder over the four interrupt causes. Produces the
// identification byte and the pending level. Purely combinational.
module uart_iic_prio
    import uart_iic_pkg::*;
(
    input  logic [EN_W-1:0]   ien,
    input  logic              ovr,
    input  logic              rx_any,
    input  logic              tx_pend,
    input  logic              modem_delta,
    input  logic              fifo_en,
    output logic [3:0]        id_code,
    output logic [DATA_W-1:0] id_val,
    output logic              pending
);
    logic [NCAUSE-1:0] hit;

    // Purpose: gate each raw cause with its enable bit (index = priority)
    always_comb begin
        hit[0] = ovr         && ien[EN_LS];
        hit[1] = rx_any      && ien[EN_RX];
        hit[2] = tx_pend     && ien[EN_TX];
        hit[3] = modem_delta && ien[EN_MS];
    end

    // Purpose: pick highest-priority cause, lowest index wins
    always_comb begin
        id_code = ID_NONE;
        for (int i = NCAUSE - 1; i >= 0; i--) begin
            if (hit[i]) id_code = CAUSE_CODE[i];
        end
    end

    // Purpose: identification byte and interrupt level
    always_comb begin
        id_val  = {(fifo_en ? FIFO_MARK : 2'b00), 2'b00, id_code};
        pending = |hit;
    end
endmodule

// File: rtl/uart_iic_top.sv
// Module: uart_iic_top
// Interrupt enable, identification and line status for a 16550-style
// port, with divisor-latch steering. Read data is combinational for the
// strobe cycle; read and write side effects land on the next edge.
// Assumes rd_en and wr_en are never high together.
module uart_iic_top
    import uart_iic_pkg::*;
#(
    parameter int          CNT_W  = 5,
    parameter int unsigned REF_HZ = 1843200,
    parameter int unsigned BAUD   = 9600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [7:0]        wdata,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              ovr_in,
    input  logic              modem_delta,
    input  logic              fifo_en,
    output logic [7:0]        rdata,
    output logic              irq
);
    localparam int unsigned DIV_RESET = REF_HZ / BAUD / 16;

    logic [EN_W-1:0]   ien_q;
    logic [DATA_W-1:0] lctl_q, div_lo_q, div_hi_q, lst_val, id_val;
    logic [3:0]        id_code;
    logic              tx_pend_q, div_sel, ovr_q, rx_any, pending;
    logic              rd_id, rd_lst, tx_clr;

    // Purpose: read-side strobes that have side effects
    always_comb begin
        rd_id  = rd_en && (addr == OFS_IID);
        rd_lst = rd_en && (addr == OFS_LST);
        tx_clr = rd_id && (id_code == ID_TX);
    end

    uart_iic_regs #(.DIV_RESET(DIV_RESET)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .tx_clr(tx_clr), .ien_q(ien_q), .lctl_q(lctl_q),
        .div_lo_q(div_lo_q), .div_hi_q(div_hi_q), .tx_pend_q(tx_pend_q),
        .div_sel(div_sel)
    );

    uart_iic_lstat #(.CNT_W(CNT_W)) u_lstat (
        .clk(clk), .rst_n(rst_n), .rd_lst(rd_lst), .rx_count(rx_count),
        .ovr_in(ovr_in), .ovr_q(ovr_q), .rx_any(rx_any), .lst_val(lst_val)
    );

    uart_iic_prio u_prio (
        .ien(ien_q), .ovr(ovr_q), .rx_any(rx_any), .tx_pend(tx_pend_q),
        .modem_delta(modem_delta), .fifo_en(fifo_en), .id_code(id_code),
        .id_val(id_val), .pending(pending)
    );

    // Purpose: read data multiplexer with divisor steering
    always_comb begin
        rdata = RD_UNUSED;
        if (div_sel && addr == OFS_DATA)     rdata = div_lo_q;
        else if (div_sel && addr == OFS_IEN) rdata = div_hi_q;
        else begin
            case (addr)
                OFS_IEN:  rdata = {{(DATA_W-EN_W){1'b0}}, ien_q};
                OFS_IID:  rdata = id_val;
                OFS_LCTL: rdata = lctl_q;
                OFS_LST:  rdata = lst_val;
                default:  rdata = RD_UNUSED;
            endcase
        end
    end

    // Purpose: level interrupt output
    assign irq = pending;
endmodule

// File: rtl/uart_iic_chk.sv
// Module: uart_iic_chk
// Property checker bound to uart_iic_top. Observes ports and the stored
// enable bits only.
module uart_iic_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [2:0]       addr,
    input logic [CNT_W-1:0] rx_count,
    input logic             ovr_in,
    input logic             fifo_en,
    input logic [7:0]       rdata,
    input logic             irq,
    input logic [3:0]       ien
);
    assert_irq_matches_id_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd2) |-> (irq == (rdata[3:0] != 4'h1)));

    assert_id_fifo_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd2) |-> (rdata[7:6] == (fifo_en ? 2'b11 : 2'b00)));

    assert_lst_fixed_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd5) |-> (rdata[6:5] == 2'b11 && rdata[0] == (rx_count != '0)));

    assert_ovr_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd5 && !ovr_in) |=> !(rd_en && addr == 3'd5 && rdata[1]));

    assert_rx_outranks_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd2 && rx_count != '0 && ien[0])
        |-> (rdata[3:0] == 4'h6 || rdata[3:0] == 4'hC));

    assert_tx_clear_on_report_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 3'd2 && rdata[3:0] == 4'h2)
        |=> !(rd_en && addr == 3'd2 && rdata[3:0] == 4'h2));
endmodule

bind uart_iic_top uart_iic_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .rx_count(rx_count), .ovr_in(ovr_in), .fifo_en(fifo_en),
    .rdata(rdata), .irq(irq), .ien(ien_q)
);

// File: tb/uart_iic_top_tb.sv
module uart_iic_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 5;
    localparam int VW = 36;
    localparam int NVEC = 44;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, ovr_in = 1'b0, modem_delta = 1'b0, fifo_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [CNT_W-1:0] rx_count = '0;
    logic [7:0] rdata;
    logic irq;
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_iic_top #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rx_count(rx_count), .ovr_in(ovr_in),
        .modem_delta(modem_delta), .fifo_en(fifo_en), .rdata(rdata), .irq(irq)
    );

    // Layout: [35]wr [34]rd [33:31]addr [30:23]wd [22:18]cnt [17]ovr [16]mdl
    //         [15]fen [14]chk_rd [13:6]exp_rd [5]chk_irq [4]exp_irq [3:0]req
    function automatic logic [VW-1:0] wv(logic [2:0] a, logic [7:0] d, logic [4:0] c, logic [3:0] rq);
        return {1'b1, 1'b0, a, d, c, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, rq};
    endfunction
    function automatic logic [VW-1:0] rv(logic [2:0] a, logic [4:0] c, logic m, logic f,
                                          logic [7:0] e, logic ci, logic ei, logic [3:0] rq);
        return {1'b0, 1'b1, a, 8'h00, c, 1'b0, m, f, 1'b1, e, ci, ei, rq};
    endfunction
    function automatic logic [VW-1:0] pv(logic [4:0] c, logic [3:0] rq);
        return {1'b0, 1'b0, 3'd0, 8'h00, c, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, rq};
    endfunction

    localparam logic [VW-1:0] VEC [NVEC] = '{
        rv(2, 0, 0, 0, 8'h01, 1, 0, 1),   // R1 idle id, irq low
        rv(1, 0, 0, 0, 8'h00, 0, 0, 1),   // R1 enables clear
        rv(5, 0, 0, 0, 8'h60, 0, 0, 8),   // R8 empty fifo
        rv(5, 3, 0, 0, 8'h61, 0, 0, 8),   // R8 data ready
        wv(1, 8'h02, 0, 5),               // R5 tx enable rising
        rv(2, 0, 0, 0, 8'h02, 1, 1, 5),   // R5 pending reported
        rv(2, 0, 0, 0, 8'h01, 1, 0, 6),   // R6 cleared by report
        wv(3, 8'h80, 0, 9),               // R9 divisor access on
        rv(0, 0, 0, 0, 8'h0C, 0, 0, 1),   // R1 divisor low reset
        rv(1, 0, 0, 0, 8'h00, 0, 0, 1),   // R1 divisor high reset
        wv(0, 8'h34, 0, 9),               // R9 goes to divisor
        wv(1, 8'h12, 0, 9),               // R9 goes to divisor
        rv(0, 0, 0, 0, 8'h34, 0, 0, 9),
        rv(1, 0, 0, 0, 8'h12, 0, 0, 9),
        wv(3, 8'h03, 0, 9),               // R9 access off
        rv(1, 0, 0, 0, 8'h02, 0, 0, 9),   // R9 enables untouched
        rv(2, 0, 0, 0, 8'h01, 1, 0, 9),   // R9 no pending from divisor write
        wv(1, 8'h02, 0, 5),               // R5 1 over 1
        rv(2, 0, 0, 0, 8'h01, 1, 0, 5),   // R5 no new pending
        wv(0, 8'h41, 0, 4),               // R4 data write
        rv(2, 0, 0, 0, 8'h02, 1, 1, 4),   // R4 pending
        rv(2, 0, 0, 0, 8'h01, 1, 0, 6),   // R6
        wv(1, 8'hFF, 0, 2),               // R2 mask upper bits
        rv(1, 0, 0, 0, 8'h0F, 0, 0, 2),   // R2
        pv(2, 3),                         // R3 overrun event
        rv(2, 2, 0, 0, 8'h06, 1, 1, 3),   // R3 overrun outranks rx
        rv(5, 2, 0, 0, 8'h63, 0, 0, 8),   // R8 overrun visible
        rv(5, 2, 0, 0, 8'h61, 0, 0, 8),   // R8 overrun cleared
        rv(2, 2, 0, 0, 8'h0C, 1, 1, 3),   // R3 rx timeout code
        wv(0, 8'h41, 2, 4),               // R4 pending hidden under rx
        rv(2, 2, 0, 0, 8'h0C, 1, 1, 6),   // R6 hidden pending kept
        rv(2, 0, 1, 0, 8'h02, 1, 1, 3),   // R3 tx over modem
        rv(2, 0, 1, 0, 8'h00, 1, 1, 3),   // R3 modem code
        rv(2, 0, 0, 0, 8'h01, 1, 0, 10),  // R10 nothing pending
        rv(2, 0, 0, 1, 8'hC1, 1, 0, 7),   // R7 fifo mark
        rv(2, 1, 0, 1, 8'hCC, 1, 1, 7),   // R7 with rx
        rv(4, 0, 0, 0, 8'hFF, 0, 0, 11),  // R11
        rv(6, 0, 0, 0, 8'hFF, 0, 0, 11),  // R11
        rv(7, 0, 0, 0, 8'hFF, 0, 0, 11),  // R11
        rv(0, 0, 0, 0, 8'hFF, 0, 0, 11),  // R11 data offset unimplemented
        wv(5, 8'hFF, 0, 11),              // R11 status write
        rv(5, 0, 0, 0, 8'h60, 1, 0, 11),  // R11 status unchanged
        wv(1, 8'h00, 0, 3),               // R3 disable all
        rv(2, 5, 0, 0, 8'h01, 1, 0, 3)    // R3 gated by enables
    };

    task automatic check(string what, int rq, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic apply(logic [VW-1:0] v);
        @(negedge clk);
        wr_en = v[35]; rd_en = v[34]; addr = v[33:31]; wdata = v[30:23];
        rx_count = v[22:18]; ovr_in = v[17]; modem_delta = v[16]; fifo_en = v[15];
        #1;
        if (v[14]) check("rdata", int'(v[3:0]), int'(rdata), int'(v[13:6]));
        if (v[5])  check("irq", int'(v[3:0]), int'(irq), int'(v[4]));
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 0; rd_en = 0; ovr_in = 0; modem_delta = 0; rx_count = '0; fifo_en = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        rst_n = 0;
        repeat (3) @(negedge clk);
        #1;
        check("reset irq", 1, int'(irq), 0);   // R1
        rst_n = 1;
        for (int i = 0; i < NVEC; i++) apply(VEC[i]);
        idle();

        // Directed: reset in the middle of activity restores defaults (R1)
        apply(wv(1, 8'h0F, 0, 1));
        apply(wv(3, 8'h80, 0, 1));
        apply(wv(0, 8'h99, 0, 1));
        apply(wv(3, 8'h00, 0, 1));
        apply(wv(0, 8'h11, 0, 1));
        apply(rv(2, 0, 0, 0, 8'h02, 1, 1, 4));  // R4 before reset
        @(negedge clk); rd_en = 0; rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        apply(rv(1, 0, 0, 0, 8'h00, 1, 0, 1));
        apply(rv(3, 0, 0, 0, 8'h00, 0, 0, 1));
        apply(rv(2, 0, 0, 0, 8'h01, 1, 0, 1));
        apply(wv(3, 8'h80, 0, 1));
        apply(rv(0, 0, 0, 0, 8'h0C, 0, 0, 1));
        apply(rv(1, 0, 0, 0, 8'h00, 0, 0, 1));

        // Directed: overrun with both line and rx enables, then drop to rx (R3)
        apply(wv(3, 8'h00, 0, 3));
        apply(wv(1, 8'h05, 0, 3));
        apply(pv(1, 3));
        apply(rv(2, 1, 0, 0, 8'h06, 1, 1, 3));
        apply(rv(5, 1, 0, 0, 8'h63, 0, 0, 8));
        apply(rv(2, 1, 0, 0, 8'h0C, 1, 1, 3));
        apply(rv(2, 0, 0, 0, 8'h01, 1, 0, 10));
        idle();
        summary();
    end
endmodule